// File: doc/BRIEF.md
# Pixel-Doubling Scanline Buffer

This block holds display lines between a tile fetch engine and a 640x480 raster output. The picture behind it is 320x240 logical pixels, 8 bits each. Storage is split into two halves of one logical line each. While one half is read out to the screen, the fetch side fills the other. When a display pair is finished, the two halves change roles. Then the fetch side is told which half is now free and which logical line it should load there.

Horizontal doubling costs no extra storage. The read slot is the horizontal count divided by two, so display columns 2k and 2k+1 both show stored pixel k, and column 0 always reads slot 0. Vertical doubling comes from keeping the same half on screen for two display lines. Each logical line is therefore fetched exactly once. The pixel output is registered, and it is forced to zero whenever active video is low.

Top module: `scanline_doubler`

## Requirements
- R1: While reset is held, `pix_out` is 0, `fill_req` is 0, `fill_half` is 1 and `fill_line` is 0. The displayed half is half 0.
- R2: For active video with `hcount` < 2*LINE_PIX, `pix_out` on the following clock equals slot `hcount>>1` of the half currently on display.
- R3: Display columns 2k and 2k+1 show the same stored pixel k, and column 0 shows slot 0.
- R4: When `active` is low, or `hcount` is beyond the stored line, `pix_out` is 0 on the following clock.
- R5: Every accepted write lands in the half that is not on display, so writes never change pixels being shown before the next swap.
- R6: A write whose address is LINE_PIX or larger is ignored and changes no stored pixel in either half.
- R7: The halves swap exactly at the clock edge where `hcount` equals H_ACTIVE and `vcount` is odd. At every other edge the displayed half holds, so both lines of a pair show identical data.
- R8: `fill_req` is high for exactly the one clock after a swap edge and low at all other times. While it is high, `fill_half` names the half that was just taken off display.
- R9: With a swap at display line v, let t = (v+4) mod V_TOTAL. The `fill_line` presented with the request is t/2 if t < V_ACTIVE, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Fetch-side write strobe |
| wr_addr | input | $clog2(LINE_PIX) | Pixel slot in the fill half |
| wr_data | input | PIX_W | Pixel value to store |
| hcount | input | HCW | Display horizontal count |
| vcount | input | VCW | Display vertical count |
| active | input | 1 | Active-video qualifier |
| pix_out | output | PIX_W | Registered display pixel |
| fill_req | output | 1 | One-clock request to fill the free half |
| fill_half | output | 1 | Half the fetch side should fill |
| fill_line | output | $clog2(V_ACTIVE/2) | Logical line to fetch |

## Verification
Every result is due one clock after the inputs that cause it. A pixel appears on the edge after its `hcount`/`active` are presented. A swap, `fill_req`, `fill_half` and `fill_line` appear on the edge after the horizontal-blank start of an odd line. The bench drives inputs at the falling edge and samples one time unit after the next rising edge. It compares against a bench-side model taken in its state from before that edge, and updates the model only after comparing. A shrunken raster is swept over three frames, with writes of varied address order, including out-of-range slots, landing on every cycle phase.

// File: rtl/scandbl_pkg.sv
package scandbl_pkg;

  // Stored slot that a display column maps to (two columns per slot).
  function automatic int unsigned col_to_slot(int unsigned h);
    return h >> 1;
  endfunction

  // True when a slot index falls inside one stored line.
  function automatic bit slot_in_line(int unsigned a, int unsigned n);
    return a < n;
  endfunction

  // Base offset of a half inside the flat storage array.
  function automatic int unsigned half_base(bit half, int unsigned n);
    return half ? n : 0;
  endfunction

  // Logical line the fetch side should load after a swap at line v.
  function automatic int unsigned next_fill_line(int unsigned v,
                                                 int unsigned vtot,
                                                 int unsigned vact);
    int unsigned t;
    t = (v + 4) % vtot;
    return (t < vact) ? (t >> 1) : 0;
  endfunction

endpackage

// File: rtl/scandbl_half_ctrl.sv
module scandbl_half_ctrl
  import scandbl_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int V_TOTAL  = 525,
  parameter int HCW      = 10,
  parameter int VCW      = 10,
  parameter int LW       = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] hcount,
  input  logic [VCW-1:0] vcount,
  output logic           disp_half,
  output logic           swap_evt,
  output logic           fill_req,
  output logic           fill_half,
  output logic [LW-1:0]  fill_line
);

  // Horizontal-blank start on an odd display line: end of a line pair.
  assign swap_evt = (32'(hcount) == H_ACTIVE) && vcount[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_half <= 1'b0;
      fill_req  <= 1'b0;
      fill_half <= 1'b1;
      fill_line <= '0;
    end else begin
      fill_req <= swap_evt;
      if (swap_evt) begin
        disp_half <= ~disp_half;
        fill_half <= disp_half;
        fill_line <= LW'(next_fill_line(32'(vcount), V_TOTAL, V_ACTIVE));
      end
    end
  end

  assert_swap_on_pair_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (disp_half != $past(disp_half)));

  assert_hold_within_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> $stable(disp_half));

  assert_req_follows_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> fill_req);

  assert_req_only_after_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> !fill_req);

  assert_fill_half_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (fill_half != disp_half));

  assert_fill_line_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (32'(fill_line) < (V_ACTIVE / 2)));

endmodule

// File: rtl/scandbl_rd_addr.sv
module scandbl_rd_addr
  import scandbl_pkg::*;
#(
  parameter int LINE_PIX = 320,
  parameter int HCW      = 10,
  parameter int AW       = 9
) (
  input  logic [HCW-1:0] hcount,
  input  logic           active,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr
);

  int unsigned slot;

  always_comb begin
    slot    = col_to_slot(32'(hcount));
    rd_en   = active && slot_in_line(slot, LINE_PIX);
    rd_addr = AW'(slot);
  end

endmodule

// File: rtl/scandbl_store.sv
module scandbl_store
  import scandbl_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_PIX = 320,
  parameter int AW       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_half,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_half,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_q
);

  localparam int DEPTH = 2 * LINE_PIX;
  localparam int IW    = $clog2(DEPTH);

  logic [PIX_W-1:0] mem [DEPTH];
  logic             wr_ok;
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    rd_idx;

  assign wr_ok  = wr_en && slot_in_line(32'(wr_addr), LINE_PIX);
  assign wr_idx = IW'(half_base(wr_half, LINE_PIX) + 32'(wr_addr));
  assign rd_idx = IW'(half_base(rd_half, LINE_PIX) + 32'(rd_addr));

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_en ? mem[rd_idx] : '0;
    end
  end

  assert_write_off_screen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_half != rd_half));

endmodule

// File: rtl/scanline_doubler.sv
module scanline_doubler
  import scandbl_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_PIX = 320,
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int V_TOTAL  = 525,
  parameter int HCW      = 10,
  parameter int VCW      = 10,
  localparam int AW      = $clog2(LINE_PIX),
  localparam int LW      = $clog2(V_ACTIVE / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [HCW-1:0]   hcount,
  input  logic [VCW-1:0]   vcount,
  input  logic             active,
  output logic [PIX_W-1:0] pix_out,
  output logic             fill_req,
  output logic             fill_half,
  output logic [LW-1:0]    fill_line
);

  logic          disp_half;
  logic          swap_evt;
  logic          rd_en;
  logic [AW-1:0] rd_addr;

  scandbl_half_ctrl #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .HCW(HCW), .VCW(VCW), .LW(LW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .disp_half(disp_half), .swap_evt(swap_evt), .fill_req(fill_req),
    .fill_half(fill_half), .fill_line(fill_line)
  );

  scandbl_rd_addr #(
    .LINE_PIX(LINE_PIX), .HCW(HCW), .AW(AW)
  ) addr_i (
    .hcount(hcount), .active(active), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  scandbl_store #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .AW(AW)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_half(~disp_half), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_half(disp_half), .rd_addr(rd_addr), .rd_q(pix_out)
  );

  assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pix_out == '0));

  assert_col0_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hcount == '0) |-> (rd_en && rd_addr == '0));

endmodule

// File: tb/scanline_doubler_tb_top.sv
module scanline_doubler_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPIX  = 6;
  localparam int HACT  = 12;
  localparam int HTOT  = 16;
  localparam int VACT  = 8;
  localparam int VTOT  = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] hcount = '0;
  logic [3:0] vcount = '0;
  logic       active = 1'b0;
  logic [7:0] pix_out;
  logic       fill_req;
  logic       fill_half;
  logic [1:0] fill_line;

  int n_tests = 0;
  int n_fail  = 0;

  int mdl [2][NPIX];
  bit vld [2][NPIX];
  bit mh = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_doubler #(
    .PIX_W(8), .LINE_PIX(NPIX), .H_ACTIVE(HACT), .V_ACTIVE(VACT),
    .V_TOTAL(VTOT), .HCW(4), .VCW(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hcount(hcount), .vcount(vcount), .active(active),
    .pix_out(pix_out), .fill_req(fill_req), .fill_half(fill_half),
    .fill_line(fill_line)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // One pixel clock: drive at falling edge, check just after rising edge.
  task automatic step(int h, int v, bit we, int wa, int wd);
    bit act;
    bit ev;
    int t;
    int expl;
    act = (h < HACT) && (v < VACT);
    @(negedge clk);
    hcount  = 4'(h);
    vcount  = 4'(v);
    active  = act;
    wr_en   = we;
    wr_addr = 3'(wa);
    wr_data = 8'(wd);
    @(posedge clk);
    #1;
    // Pixel result, against model state before this edge.
    if (!act) begin
      chk("R4 blank output", int'(pix_out), 0);
    end else if (vld[mh][h/2]) begin
      if (h % 2 == 1)
        chk("R3 doubled column (R5 R6 R7)", int'(pix_out), mdl[mh][h/2]);
      else
        chk("R2 pixel slot (R5 R6 R7)", int'(pix_out), mdl[mh][h/2]);
    end
    // Writes land in the off-screen half; out-of-range slots dropped.
    if (we && wa < NPIX) begin
      mdl[!mh][wa] = wd;
      vld[!mh][wa] = 1'b1;
    end
    // Swap and fill request.
    ev = (h == HACT) && (v % 2 == 1);
    chk("R8 fill_req pulse", int'(fill_req), int'(ev));
    if (ev) begin
      chk("R8 fill_half", int'(fill_half), int'(mh));
      t = (v + 4) % VTOT;
      expl = (t < VACT) ? t / 2 : 0;
      chk("R9 fill_line", int'(fill_line), expl);
      mh = ~mh;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < NPIX; j++) begin
        mdl[i][j] = 0;
        vld[i][j] = 1'b0;
      end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pix_out", int'(pix_out), 0);
    chk("R1 reset fill_req", int'(fill_req), 0);
    chk("R1 reset fill_half", int'(fill_half), 1);
    chk("R1 reset fill_line", int'(fill_line), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < VTOT; v++) begin
        for (int h = 0; h < HTOT; h++) begin
          bit we;
          int wa;
          int wd;
          we = ((h + v + f) % 3) != 2;
          wa = (h + 3 * v + f) % 8;
          wd = (f * 97 + v * 37 + h * 11 + 5) % 256;
          step(h, v, we, wa, wd);
        end
      end
    end
    summary();
    $finish;
  end

endmodule